// File: doc/BRIEF.md
# Non-Blocking Write-Back Data Cache Bank

This block is one bank of a banked data cache shared by several hardware threads. It is direct-mapped and write-back. A load that hits returns its word to the register file of the requesting thread. A store that hits updates the line and marks it dirty. A miss does not hold up the bank: it is recorded in a small miss queue, a line request is sent to the next memory level, and later requests that hit continue to be served while the miss is outstanding.

When the refill data returns, the line is installed in the bank. A load miss then writes its word to the thread's register file. A store miss merges its word into the refilled line and leaves the line dirty. The requester sees a single `stall` output. While `stall` is high, the request presented in that cycle is not taken and must be held. The bank raises `stall` in four cases: when it copies a dirty victim out to the write buffer, when a miss targets a set that already has a miss in flight, when the miss queue is full, and when a load hit needs the same thread's register write port as a refill in the same cycle.

Top module: `cache_bank`

## Requirements
- R1: After reset every line is invalid and no register write, line request or write-buffer transfer is pending. `stall` is low while no request is presented.
- R2: A load that hits and is accepted in cycle T drives `rfWe[thread]` in cycle T+1, with the requested word on that thread's `rfData` slice and the destination register on its `rfDest` slice.
- R3: A store that hits writes its word into the line, marks the line dirty and causes no register write. A later load of that word returns the stored value.
- R4: A miss with no stall condition is accepted and queued. A refill presented on `memRespValid` always belongs to the oldest queue entry. A load's refill writes the requested word to its thread's register port in the cycle after the refill, and the line hits from then on.
- R5: Load and store hits are accepted without stall while misses are outstanding, except in the case of R11.
- R6: A miss whose victim line is valid and dirty stalls for one cycle. In the next cycle `wbufValid` is high, with the victim's line address and full line data, and the line is invalid.
- R7: A miss to a set that holds a queued miss stalls until the cycle after that set's refill.
- R8: A miss that finds the miss queue full stalls, until a refill frees an entry.
- R9: Line requests leave in queue order, one per `memReqValid` cycle. Two requests are at least `ISSUE_GAP` cycles apart.
- R10: A store miss writes no register. On refill, its word replaces the matching word of the returned line and the line becomes dirty. A later eviction of that line writes back the merged data.
- R11: When a load refill and a load hit for the same thread coincide, the refill takes the register write and the hit is stalled. Hits of other threads, and store hits, proceed in that cycle.
- R12: Address fields: word offset is `reqAddr[OFF_W-1:0]`, set index is the next `IDX_W` bits, and tag is the remainder. A line address is `reqAddr[ADDR_W-1:OFF_W]`, and its low `IDX_W` bits are the set. Word k of a line occupies bits `[k*DATA_W +: DATA_W]` of line data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request present |
| reqWrite | input | 1 | 1 = store, 0 = load |
| reqAddr | input | ADDR_W | Word address |
| reqWdata | input | DATA_W | Store data |
| reqThread | input | THR_W | Issuing thread |
| reqDest | input | REG_W | Destination register of a load |
| stall | output | 1 | Request not taken this cycle |
| rfWe | output | THREADS | Per-thread register write strobe |
| rfDest | output | THREADS*REG_W | Per-thread destination register |
| rfData | output | THREADS*DATA_W | Per-thread write data |
| memReqValid | output | 1 | Line request to next level |
| memReqLine | output | ADDR_W-OFF_W | Requested line address |
| memRespValid | input | 1 | Refill data present, oldest request |
| memRespData | input | LINE_WORDS*DATA_W | Refill line |
| wbufValid | output | 1 | Dirty victim to write buffer |
| wbufLine | output | ADDR_W-OFF_W | Victim line address |
| wbufData | output | LINE_WORDS*DATA_W | Victim line data |

## Verification
The bench aims at these corner cases:
- Stalls for a second access to a set with a miss in flight, and for a full miss queue. If the set check were missing, a duplicate request would be issued or a refill would overwrite a fresher line. If the full check were missing, a queue entry would be overwritten and its refill would go to the wrong thread.
- A dirty eviction. A design that skipped the one-cycle copy-out would lose stored data, or would report a wrong victim address on `wbufLine`.
- A store miss. A design that wrote the refilled line without merging the store word would write back stale data at the next eviction.
- A long run of same-thread hits across a refill. A wrong arbiter would either drop one of the two register writes or stall the other thread.

// File: rtl/cache_bank_pkg.sv
package cache_bank_pkg;

  // One-cycle action strobes from the control to the datapath.
  typedef struct packed {
    logic hitRead;   // load hit: return word to register port
    logic hitWrite;  // store hit: update word, set dirty
    logic copyOut;   // dirty victim to write buffer, invalidate
    logic alloc;     // miss queued: invalidate the set
    logic refill;    // oldest queued line arrives
  } bankStrobes_t;

endpackage

// File: rtl/cache_bank_ctrl.sv
module cache_bank_ctrl
  import cache_bank_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int DATA_W     = 16,
  parameter int LINE_WORDS = 2,
  parameter int SETS       = 8,
  parameter int THREADS    = 2,
  parameter int REG_W      = 5,
  parameter int MQ_DEPTH   = 2,
  parameter int ISSUE_GAP  = 4
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic                              reqValid,
  input  logic                              reqWrite,
  input  logic [ADDR_W-1:0]                 reqAddr,
  input  logic [DATA_W-1:0]                 reqWdata,
  input  logic [(THREADS>1?$clog2(THREADS):1)-1:0] reqThread,
  input  logic [REG_W-1:0]                  reqDest,
  input  logic                              lookupHit,
  input  logic                              victimDirty,
  input  logic                              memRespValid,
  output logic                              stall,
  output bankStrobes_t                      strobes,
  output logic                              memReqValid,
  output logic [ADDR_W-$clog2(LINE_WORDS)-1:0] memReqLine,
  output logic [ADDR_W-$clog2(LINE_WORDS)-1:0] refLine,
  output logic [$clog2(LINE_WORDS)-1:0]     refOff,
  output logic                              refStore,
  output logic [DATA_W-1:0]                 refWdata,
  output logic [(THREADS>1?$clog2(THREADS):1)-1:0] refThread,
  output logic [REG_W-1:0]                  refDest
);
  localparam int OFF_W    = $clog2(LINE_WORDS);
  localparam int IDX_W    = $clog2(SETS);
  localparam int LINE_A_W = ADDR_W - OFF_W;
  localparam int THR_W    = (THREADS > 1) ? $clog2(THREADS) : 1;
  localparam int PTR_W    = (MQ_DEPTH > 1) ? $clog2(MQ_DEPTH) : 1;
  localparam int CNT_W    = $clog2(MQ_DEPTH + 1);
  localparam int GAP_W    = $clog2(ISSUE_GAP + 1);

  // Miss queue payload
  logic [LINE_A_W-1:0] qLine   [MQ_DEPTH];
  logic [OFF_W-1:0]    qOff    [MQ_DEPTH];
  logic                qStore  [MQ_DEPTH];
  logic [DATA_W-1:0]   qWdata  [MQ_DEPTH];
  logic [THR_W-1:0]    qThread [MQ_DEPTH];
  logic [REG_W-1:0]    qDest   [MQ_DEPTH];

  logic [MQ_DEPTH-1:0] slotBusy, setMatch;
  logic [PTR_W-1:0]    headPtr, tailPtr, issPtr;
  logic [CNT_W-1:0]    count, issuedNum;
  logic [GAP_W-1:0]    gapCnt;

  logic [IDX_W-1:0] reqIdx;
  logic             pendSet, queueFull, portClash;

  assign reqIdx = reqAddr[OFF_W +: IDX_W];

  for (genvar s = 0; s < MQ_DEPTH; s++) begin : g_setMatch
    assign setMatch[s] = slotBusy[s] && (qLine[s][IDX_W-1:0] == reqIdx);
  end

  assign pendSet   = |setMatch;
  assign queueFull = (count == CNT_W'(MQ_DEPTH));

  assign refLine   = qLine[headPtr];
  assign refOff    = qOff[headPtr];
  assign refStore  = qStore[headPtr];
  assign refWdata  = qWdata[headPtr];
  assign refThread = qThread[headPtr];
  assign refDest   = qDest[headPtr];

  assign portClash   = memRespValid && !refStore && (refThread == reqThread);
  assign memReqValid = (gapCnt == '0) && (issuedNum < count);
  assign memReqLine  = qLine[issPtr];

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(MQ_DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    strobes        = '0;
    strobes.refill = memRespValid;
    stall          = 1'b0;
    if (reqValid) begin
      if (lookupHit) begin
        if (reqWrite)       strobes.hitWrite = 1'b1;
        else if (portClash) stall = 1'b1;
        else                strobes.hitRead = 1'b1;
      end else if (victimDirty) begin
        stall           = 1'b1;
        strobes.copyOut = 1'b1;
      end else if (pendSet || queueFull) begin
        stall = 1'b1;
      end else begin
        strobes.alloc = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      headPtr   <= '0;
      tailPtr   <= '0;
      issPtr    <= '0;
      count     <= '0;
      issuedNum <= '0;
      gapCnt    <= '0;
      slotBusy  <= '0;
    end else begin
      if (strobes.alloc) begin
        tailPtr           <= nextPtr(tailPtr);
        slotBusy[tailPtr] <= 1'b1;
      end
      if (strobes.refill) begin
        headPtr           <= nextPtr(headPtr);
        slotBusy[headPtr] <= 1'b0;
      end
      case ({strobes.alloc, strobes.refill})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
      case ({memReqValid, strobes.refill})
        2'b10:   issuedNum <= issuedNum + 1'b1;
        2'b01:   issuedNum <= issuedNum - 1'b1;
        default: issuedNum <= issuedNum;
      endcase
      if (memReqValid) begin
        issPtr <= nextPtr(issPtr);
        gapCnt <= GAP_W'(ISSUE_GAP - 1);
      end else if (gapCnt != '0) begin
        gapCnt <= gapCnt - 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (strobes.alloc) begin
      qLine[tailPtr]   <= reqAddr[ADDR_W-1:OFF_W];
      qOff[tailPtr]    <= reqAddr[OFF_W-1:0];
      qStore[tailPtr]  <= reqWrite;
      qWdata[tailPtr]  <= reqWdata;
      qThread[tailPtr] <= reqThread;
      qDest[tailPtr]   <= reqDest;
    end
  end

endmodule

// File: rtl/cache_bank_dp.sv
module cache_bank_dp
  import cache_bank_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int DATA_W     = 16,
  parameter int LINE_WORDS = 2,
  parameter int SETS       = 8,
  parameter int THREADS    = 2,
  parameter int REG_W      = 5
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic [ADDR_W-1:0]                 reqAddr,
  input  logic [DATA_W-1:0]                 reqWdata,
  input  logic [(THREADS>1?$clog2(THREADS):1)-1:0] reqThread,
  input  logic [REG_W-1:0]                  reqDest,
  input  bankStrobes_t                      strobes,
  input  logic [ADDR_W-$clog2(LINE_WORDS)-1:0] refLine,
  input  logic [$clog2(LINE_WORDS)-1:0]     refOff,
  input  logic                              refStore,
  input  logic [DATA_W-1:0]                 refWdata,
  input  logic [(THREADS>1?$clog2(THREADS):1)-1:0] refThread,
  input  logic [REG_W-1:0]                  refDest,
  input  logic [LINE_WORDS*DATA_W-1:0]      memRespData,
  output logic                              lookupHit,
  output logic                              victimDirty,
  output logic [THREADS-1:0]                rfWe,
  output logic [THREADS*REG_W-1:0]          rfDest,
  output logic [THREADS*DATA_W-1:0]         rfData,
  output logic                              wbufValid,
  output logic [ADDR_W-$clog2(LINE_WORDS)-1:0] wbufLine,
  output logic [LINE_WORDS*DATA_W-1:0]      wbufData
);
  localparam int OFF_W     = $clog2(LINE_WORDS);
  localparam int IDX_W     = $clog2(SETS);
  localparam int TAG_W     = ADDR_W - OFF_W - IDX_W;
  localparam int LINE_BITS = LINE_WORDS * DATA_W;

  logic [TAG_W-1:0]     tagArr  [SETS];
  logic [LINE_BITS-1:0] dataArr [SETS];
  logic [SETS-1:0]      validArr, dirtyArr;

  logic [OFF_W-1:0]     reqOff;
  logic [IDX_W-1:0]     reqIdx, refIdx;
  logic [TAG_W-1:0]     reqTag;
  logic [DATA_W-1:0]    hitWord, refWord;
  logic [LINE_BITS-1:0] refMerged;

  assign reqOff = reqAddr[OFF_W-1:0];
  assign reqIdx = reqAddr[OFF_W +: IDX_W];
  assign reqTag = reqAddr[ADDR_W-1 -: TAG_W];
  assign refIdx = refLine[IDX_W-1:0];

  assign lookupHit   = validArr[reqIdx] && (tagArr[reqIdx] == reqTag);
  assign victimDirty = validArr[reqIdx] && dirtyArr[reqIdx];
  assign hitWord     = dataArr[reqIdx][int'(reqOff)*DATA_W +: DATA_W];
  assign refWord     = memRespData[int'(refOff)*DATA_W +: DATA_W];

  always_comb begin
    refMerged = memRespData;
    if (refStore) refMerged[int'(refOff)*DATA_W +: DATA_W] = refWdata;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validArr <= '0;
      dirtyArr <= '0;
    end else begin
      if (strobes.copyOut || strobes.alloc) begin
        validArr[reqIdx] <= 1'b0;
        dirtyArr[reqIdx] <= 1'b0;
      end
      if (strobes.hitWrite) dirtyArr[reqIdx] <= 1'b1;
      if (strobes.refill) begin
        validArr[refIdx] <= 1'b1;
        dirtyArr[refIdx] <= refStore;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (strobes.hitWrite) dataArr[reqIdx][int'(reqOff)*DATA_W +: DATA_W] <= reqWdata;
    if (strobes.refill) begin
      tagArr[refIdx]  <= refLine[IDX_W +: TAG_W];
      dataArr[refIdx] <= refMerged;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rfWe      <= '0;
      rfDest    <= '0;
      rfData    <= '0;
      wbufValid <= 1'b0;
      wbufLine  <= '0;
      wbufData  <= '0;
    end else begin
      rfWe      <= '0;
      wbufValid <= strobes.copyOut;
      if (strobes.copyOut) begin
        wbufLine <= {tagArr[reqIdx], reqIdx};
        wbufData <= dataArr[reqIdx];
      end
      if (strobes.hitRead) begin
        rfWe[reqThread]                        <= 1'b1;
        rfDest[int'(reqThread)*REG_W +: REG_W] <= reqDest;
        rfData[int'(reqThread)*DATA_W +: DATA_W] <= hitWord;
      end
      if (strobes.refill && !refStore) begin
        rfWe[refThread]                          <= 1'b1;
        rfDest[int'(refThread)*REG_W +: REG_W]   <= refDest;
        rfData[int'(refThread)*DATA_W +: DATA_W] <= refWord;
      end
    end
  end

endmodule

// File: rtl/cache_bank.sv
module cache_bank
  import cache_bank_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int DATA_W     = 16,
  parameter int LINE_WORDS = 2,
  parameter int SETS       = 8,
  parameter int THREADS    = 2,
  parameter int REG_W      = 5,
  parameter int MQ_DEPTH   = 2,
  parameter int ISSUE_GAP  = 4
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic                              reqValid,
  input  logic                              reqWrite,
  input  logic [ADDR_W-1:0]                 reqAddr,
  input  logic [DATA_W-1:0]                 reqWdata,
  input  logic [(THREADS>1?$clog2(THREADS):1)-1:0] reqThread,
  input  logic [REG_W-1:0]                  reqDest,
  output logic                              stall,
  output logic [THREADS-1:0]                rfWe,
  output logic [THREADS*REG_W-1:0]          rfDest,
  output logic [THREADS*DATA_W-1:0]         rfData,
  output logic                              memReqValid,
  output logic [ADDR_W-$clog2(LINE_WORDS)-1:0] memReqLine,
  input  logic                              memRespValid,
  input  logic [LINE_WORDS*DATA_W-1:0]      memRespData,
  output logic                              wbufValid,
  output logic [ADDR_W-$clog2(LINE_WORDS)-1:0] wbufLine,
  output logic [LINE_WORDS*DATA_W-1:0]      wbufData
);
  localparam int OFF_W    = $clog2(LINE_WORDS);
  localparam int LINE_A_W = ADDR_W - OFF_W;
  localparam int THR_W    = (THREADS > 1) ? $clog2(THREADS) : 1;

  bankStrobes_t         strobes;
  logic                 lookupHit, victimDirty, refStore;
  logic [LINE_A_W-1:0]  refLine;
  logic [OFF_W-1:0]     refOff;
  logic [DATA_W-1:0]    refWdata;
  logic [THR_W-1:0]     refThread;
  logic [REG_W-1:0]     refDest;

  cache_bank_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINE_WORDS(LINE_WORDS), .SETS(SETS),
    .THREADS(THREADS), .REG_W(REG_W), .MQ_DEPTH(MQ_DEPTH), .ISSUE_GAP(ISSUE_GAP)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .reqThread(reqThread), .reqDest(reqDest),
    .lookupHit(lookupHit), .victimDirty(victimDirty), .memRespValid(memRespValid),
    .stall(stall), .strobes(strobes), .memReqValid(memReqValid), .memReqLine(memReqLine),
    .refLine(refLine), .refOff(refOff), .refStore(refStore), .refWdata(refWdata),
    .refThread(refThread), .refDest(refDest)
  );

  cache_bank_dp #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINE_WORDS(LINE_WORDS), .SETS(SETS),
    .THREADS(THREADS), .REG_W(REG_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .reqThread(reqThread), .reqDest(reqDest), .strobes(strobes),
    .refLine(refLine), .refOff(refOff), .refStore(refStore), .refWdata(refWdata),
    .refThread(refThread), .refDest(refDest), .memRespData(memRespData),
    .lookupHit(lookupHit), .victimDirty(victimDirty),
    .rfWe(rfWe), .rfDest(rfDest), .rfData(rfData),
    .wbufValid(wbufValid), .wbufLine(wbufLine), .wbufData(wbufData)
  );

endmodule

// File: rtl/cache_bank_checker.sv
module cache_bank_checker #(
  parameter int THREADS   = 2,
  parameter int ISSUE_GAP = 4
) (
  input logic               clk,
  input logic               rstN,
  input logic               reqValid,
  input logic               stall,
  input logic               lookupHit,
  input logic               memRespValid,
  input logic               memReqValid,
  input logic               wbufValid,
  input logic [THREADS-1:0] rfWe
);
  localparam int SINCE_W = $clog2(ISSUE_GAP + 1) + 1;

  // Cycles since the last line request, saturating at ISSUE_GAP
  logic [SINCE_W-1:0] sinceReq;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                   sinceReq <= SINCE_W'(ISSUE_GAP);
    else if (memReqValid)                        sinceReq <= SINCE_W'(1);
    else if (sinceReq < SINCE_W'(ISSUE_GAP))     sinceReq <= sinceReq + 1'b1;
  end

  // R9: requests are spaced at least ISSUE_GAP cycles apart
  a_r9_issue_gap: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> (sinceReq >= SINCE_W'(ISSUE_GAP)));

  // R6: a write-buffer transfer follows a copy-out stall
  a_r6_copy_stalls: assert property (@(posedge clk) disable iff (!rstN)
    wbufValid |-> $past(stall));

  // R2: every register write comes from an accepted request or a refill
  a_r2_rf_has_source: assert property (@(posedge clk) disable iff (!rstN)
    (|rfWe) |-> ($past(reqValid && !stall) || $past(memRespValid)));

  // R5: without a refill in the cycle, a hit is never stalled
  a_r5_hit_accepted: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && lookupHit && !memRespValid) |-> !stall);

endmodule

bind cache_bank cache_bank_checker #(.THREADS(THREADS), .ISSUE_GAP(ISSUE_GAP)) u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .stall(stall),
  .lookupHit(lookupHit), .memRespValid(memRespValid), .memReqValid(memReqValid),
  .wbufValid(wbufValid), .rfWe(rfWe)
);

// File: tb/cache_bank_test.sv
module cache_bank_test;
  localparam int ADDR_W = 12, DATA_W = 16, LW = 2, SETS = 8, THREADS = 2;
  localparam int REG_W = 5, DEPTH = 2, GAP = 4, MISS_LAT = 6;
  localparam int LINE_A_W = ADDR_W - 1, LINE_BITS = LW * DATA_W;

  logic clk = 1'b0, rstN = 1'b0;
  logic reqValid = 0, reqWrite = 0;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic [DATA_W-1:0] reqWdata = '0;
  logic [0:0] reqThread = '0;
  logic [REG_W-1:0] reqDest = '0;
  logic stall, memReqValid, wbufValid;
  logic [THREADS-1:0] rfWe;
  logic [THREADS*REG_W-1:0] rfDest;
  logic [THREADS*DATA_W-1:0] rfData;
  logic [LINE_A_W-1:0] memReqLine, wbufLine;
  logic memRespValid = 0;
  logic [LINE_BITS-1:0] memRespData = '0, wbufData;

  always #2.5 clk = ~clk;

  cache_bank uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite), .reqAddr(reqAddr),
    .reqWdata(reqWdata), .reqThread(reqThread), .reqDest(reqDest), .stall(stall),
    .rfWe(rfWe), .rfDest(rfDest), .rfData(rfData), .memReqValid(memReqValid),
    .memReqLine(memReqLine), .memRespValid(memRespValid), .memRespData(memRespData),
    .wbufValid(wbufValid), .wbufLine(wbufLine), .wbufData(wbufData)
  );

  int total = 0, fails = 0;

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int memWord(int line, int k);
    return (line * 37 + k * 11 + 5) & 16'hffff;
  endfunction

  typedef struct { bit v; bit w; int a; int d; int t; int r; } stim_t;
  typedef struct { int line; int off; bit store; int wdata; int thr; int dest; } ent_t;
  stim_t stim[$];
  ent_t  mq[$];
  int respDue[$], respLine[$];

  // Reference model state
  bit mValid[SETS], mDirty[SETS];
  int mTag[SETS], mData[SETS][LW];
  int issued = 0, gapM = 0;
  bit expWe[THREADS];
  int expDest[THREADS], expData[THREADS], expSrc[THREADS];
  bit expWbV = 0;
  int expWbLine = 0;
  logic [LINE_BITS-1:0] expWbData = '0;
  int nPend = 0, nFull = 0, nCopy = 0, nClash = 0, nBusyHit = 0, nDual = 0, nStRef = 0;
  int lastReq = -1000;

  function automatic int mk(int tag, int idx, int off);
    return (tag << 4) | (idx << 1) | off;
  endfunction

  task automatic add(bit w, int tag, int idx, int off, int d, int t, int r);
    stim_t s;
    s.v = 1; s.w = w; s.a = mk(tag, idx, off); s.d = d; s.t = t; s.r = r;
    stim.push_back(s);
  endtask

  task automatic idle(int n);
    stim_t s;
    s = '{default: 0};
    for (int i = 0; i < n; i++) stim.push_back(s);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog all requirements actual=hung expected=finished");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin : main
    int cyc, drain;
    for (int s = 0; s < SETS; s++) begin mValid[s] = 0; mDirty[s] = 0; end
    for (int t = 0; t < THREADS; t++) begin expWe[t] = 0; expSrc[t] = 0; end

    // Stimulus program
    add(0, 1, 1, 0, 0, 0, 3);       // miss
    add(0, 1, 1, 1, 0, 1, 4);       // same set pending
    add(0, 2, 2, 0, 0, 1, 5);
    add(0, 3, 3, 0, 0, 0, 6);
    add(0, 4, 4, 0, 0, 0, 7);       // queue full
    add(1, 1, 1, 1, 'hAAAA, 0, 0);  // store hit
    add(0, 1, 1, 1, 0, 1, 8);       // read back
    add(0, 9, 1, 0, 0, 0, 9);       // dirty victim
    add(1, 5, 5, 1, 'h1234, 1, 0);  // store miss
    idle(3);
    add(0, 2, 2, 1, 0, 0, 10);
    add(0, 6, 6, 0, 0, 1, 11);      // thread 1 load miss
    add(0, 7, 7, 0, 0, 0, 12);      // thread 0 load miss
    for (int i = 0; i < 24; i++) add(0, 2, 2, 0, 0, 0, 13 + (i % 16));
    add(0, 13, 5, 0, 0, 0, 1);      // evict merged dirty line
    add(0, 13, 5, 1, 0, 1, 2);

    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    // R1: reset state
    chk(stall == 1'b0, "R1", "stall after reset", stall, 0);
    chk(rfWe == '0, "R1", "rfWe after reset", rfWe, 0);
    chk(memReqValid == 1'b0, "R1", "memReqValid after reset", memReqValid, 0);
    chk(wbufValid == 1'b0, "R1", "wbufValid after reset", wbufValid, 0);

    cyc = 0; drain = 0;
    while (stim.size() > 0 || drain < 40) begin
      bit rV, rW, hit, pend, copy, full, clash, mStall, acc, respNow, issue;
      int rA, rD, rT, rR, idx, tag, off, issueLine;
      ent_t e;
      string why;
      @(negedge clk);
      cyc++;
      if (stim.size() == 0) drain++;
      if (stim.size() > 0) begin
        rV = stim[0].v; rW = stim[0].w; rA = stim[0].a;
        rD = stim[0].d; rT = stim[0].t; rR = stim[0].r;
      end else begin
        rV = 0; rW = 0; rA = 0; rD = 0; rT = 0; rR = 0;
      end
      reqValid = rV; reqWrite = rW; reqAddr = rA[ADDR_W-1:0];
      reqWdata = rD[DATA_W-1:0]; reqThread = rT[0:0]; reqDest = rR[REG_W-1:0];
      respNow = respDue.size() > 0 && respDue[0] == cyc;
      memRespValid = respNow;
      if (respNow) begin
        for (int k = 0; k < LW; k++) memRespData[k*DATA_W +: DATA_W] = memWord(respLine[0], k);
        void'(respDue.pop_front()); void'(respLine.pop_front());
      end
      #1;

      // Model: this cycle's decision (R12 field layout)
      off = rA & 1; idx = (rA >> 1) % SETS; tag = rA >> 4;
      hit   = mValid[idx] && mTag[idx] == tag;
      pend  = 0;
      foreach (mq[i]) if (mq[i].line % SETS == idx) pend = 1;
      full  = mq.size() == DEPTH;
      clash = rV && hit && !rW && respNow && !mq[0].store && mq[0].thr == rT;
      copy  = rV && !hit && mValid[idx] && mDirty[idx];
      mStall = clash || copy || (rV && !hit && !copy && (pend || full));
      acc   = rV && !mStall;
      issue = gapM == 0 && issued < mq.size();
      issueLine = issue ? mq[issued].line : 0;

      why = clash ? "R11" : copy ? "R6" : (rV && !hit && pend) ? "R7" :
            (rV && !hit && full) ? "R8" : "R5";
      chk(stall == mStall, why, "stall", stall, mStall);
      chk(memReqValid == issue, "R9", "memReqValid", memReqValid, issue);
      if (issue) chk(memReqLine == LINE_A_W'(issueLine), "R4", "memReqLine", memReqLine, issueLine);
      if (memReqValid) begin
        chk(cyc - lastReq >= GAP, "R9", "request spacing", cyc - lastReq, GAP);
        lastReq = cyc;
      end
      for (int t = 0; t < THREADS; t++) begin
        string rq;
        rq = (expSrc[t] == 2) ? "R4/R12" : (expSrc[t] == 1) ? "R2/R3" : "R2/R10";
        chk(rfWe[t] == expWe[t], rq, $sformatf("rfWe[%0d]", t), rfWe[t], expWe[t]);
        if (expWe[t]) begin
          chk(rfDest[t*REG_W +: REG_W] == REG_W'(expDest[t]), rq, "rfDest",
              rfDest[t*REG_W +: REG_W], expDest[t]);
          chk(rfData[t*DATA_W +: DATA_W] == DATA_W'(expData[t]), rq, "rfData",
              rfData[t*DATA_W +: DATA_W], expData[t]);
        end
      end
      chk(wbufValid == expWbV, "R6", "wbufValid", wbufValid, expWbV);
      if (expWbV) begin
        chk(wbufLine == LINE_A_W'(expWbLine), "R6", "wbufLine", wbufLine, expWbLine);
        chk(wbufData == expWbData, "R6/R10", "wbufData", wbufData, expWbData);
      end

      // Event tallies for coverage of the scenarios
      if (clash) nClash++;
      if (copy) nCopy++;
      if (rV && !hit && !copy && pend) nPend++;
      if (rV && !hit && !copy && !pend && full) nFull++;
      if (acc && hit && mq.size() > 0) nBusyHit++;

      // Model: registered outputs after this edge
      for (int t = 0; t < THREADS; t++) begin expWe[t] = 0; expSrc[t] = 0; end
      expWbV = copy;
      if (copy) begin
        expWbLine = mTag[idx] * SETS + idx;
        for (int k = 0; k < LW; k++) expWbData[k*DATA_W +: DATA_W] = DATA_W'(mData[idx][k]);
      end
      if (acc && hit && !rW) begin
        expWe[rT] = 1; expDest[rT] = rR; expData[rT] = mData[idx][off]; expSrc[rT] = 1;
      end
      if (respNow) begin
        int w[LW];
        int ridx;
        e = mq[0];
        ridx = e.line % SETS;
        for (int k = 0; k < LW; k++) w[k] = memWord(e.line, k);
        if (e.store) begin w[e.off] = e.wdata; nStRef++; end
        else begin
          if (expWe[e.thr] == 0 && expWe[1 - e.thr] == 1) nDual++;
          expWe[e.thr] = 1; expDest[e.thr] = e.dest; expData[e.thr] = w[e.off]; expSrc[e.thr] = 2;
        end
        mValid[ridx] = 1; mDirty[ridx] = e.store; mTag[ridx] = e.line / SETS;
        for (int k = 0; k < LW; k++) mData[ridx][k] = w[k];
      end

      // Model: state after this edge
      if (copy) begin mValid[idx] = 0; mDirty[idx] = 0; end
      if (acc && hit && rW) begin mData[idx][off] = rD & 16'hffff; mDirty[idx] = 1; end
      if (acc && !hit) begin
        ent_t n;
        n.line = rA >> 1; n.off = off; n.store = rW; n.wdata = rD & 16'hffff;
        n.thr = rT; n.dest = rR;
        mq.push_back(n);
        mValid[idx] = 0;
      end
      if (respNow) begin void'(mq.pop_front()); issued--; end
      if (issue) begin
        issued++; gapM = GAP - 1;
        respDue.push_back(cyc + MISS_LAT); respLine.push_back(issueLine);
      end else if (gapM > 0) gapM--;

      if (stim.size() > 0 && (!rV || acc)) void'(stim.pop_front());
      @(posedge clk);
    end

    // Scenario coverage: each corner case was reached
    chk(nPend > 0, "R7", "pending-set stalls seen", nPend, 1);
    chk(nFull > 0, "R8", "full-queue stalls seen", nFull, 1);
    chk(nCopy > 0, "R6", "copy-out stalls seen", nCopy, 1);
    chk(nClash > 0, "R11", "port clashes seen", nClash, 1);
    chk(nDual > 0, "R11", "two-thread writes in one cycle", nDual, 1);
    chk(nBusyHit > 0, "R5", "hits served with misses outstanding", nBusyHit, 1);
    chk(nStRef > 0, "R10", "store-miss refills seen", nStRef, 1);
    chk(mq.size() == 0, "R4", "all misses refilled", mq.size(), 0);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule